// File: doc/BRIEF.md
# Block-Delivery Receive Byte Pool

This block holds received serial characters in a 32-entry pool. It does not hand them over one pop at a time. It gathers them and hands the host a whole block, announced by an event. There are two ways a block is handed over. A full pool does it on its own. A force command from the host does it for a partial fill, and the host normally sends that command after an idle timeout event. Each stored byte carries a 2-bit status code that comes from its parity, framing and break flags.

While a block is outstanding, the host reads it at random indices 0 to count-1. The host then gives the release command, which frees exactly those bytes. Bytes that arrive while a block is outstanding are kept and start the next block. A byte that finds the pool full is dropped and raises an overflow event. A reset command empties the pool at any time.

Top module: `rxblk_fifo`

## Requirements
- R1: Accepted bytes are stored in arrival order. While a block is outstanding, `rd_en` with index i returns that block's byte i and its status on `rd_data`/`rd_stat` one clock later. The same values stay readable until the release command.
- R2: When the pool holds 32 bytes and no block is outstanding, `ev_full` pulses for one cycle. On the next clock after the pool became full, `blk_ready` rises and `blk_count` reads 0 (32 modulo 32).
- R3: `cmd_force` with no block outstanding and n stored bytes (1 to 31) pulses `ev_term`, raises `blk_ready` and sets `blk_count` to n. With zero stored bytes, or while a block is outstanding, the command has no effect.
- R4: With bytes stored and no block outstanding, `ev_timeout` pulses once, exactly TIMEOUT_CHARS*CHAR_CYCLES clocks after the clock that accepted the last byte. It does not pulse again until another byte arrives.
- R5: `cmd_release` frees the outstanding block and drops `blk_ready`. Bytes accepted while the block was outstanding are kept, and the next block begins at index 0 with the first of them.
- R6: A byte that arrives while 32 bytes are stored is discarded and pulses `ev_ovf`. The stored bytes are unchanged.
- R7: Status codes: 3 = break, 2 = parity error, 1 = framing error, 0 = clean. Break wins over parity, and parity wins over framing.
- R8: An accepted byte flagged with `rx_brk` pulses `ev_brk` on the clock after it is accepted.
- R9: `cmd_reset` empties the pool and clears any outstanding block. A following force finds nothing, and the next byte lands at index 0.
- R10: After `rst`, all event outputs and `blk_ready` are low and `blk_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DW | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Character is a break |
| rd_en | input | 1 | Host read strobe |
| rd_idx | input | AW | Index inside the outstanding block |
| rd_data | output | DW | Read character, one clock after `rd_en` |
| rd_stat | output | 2 | Read status code |
| cmd_release | input | 1 | Free the outstanding block |
| cmd_force | input | 1 | Hand over pending bytes as a partial block |
| cmd_reset | input | 1 | Empty the pool |
| ev_full | output | 1 | Full block handed over |
| ev_term | output | 1 | Partial block handed over |
| ev_timeout | output | 1 | Stored bytes idle |
| ev_ovf | output | 1 | Character dropped, pool full |
| ev_brk | output | 1 | Break character stored |
| blk_ready | output | 1 | A block is outstanding |
| blk_count | output | AW | Outstanding block length modulo DEPTH |

## Verification
The bench builds the block with DEPTH = 32 and CHAR_CYCLES = 8, so the idle limit is 32 clocks. This makes filling the pool, the overflow that follows, and the exact clock of the timeout all reachable within a few dozen cycles. The modulo-32 count of a full block is checked. The bench also checks the wrap of the base pointer after a partial block, and bytes that arrive while a block is outstanding.

// File: rtl/rxblk_pkg.sv
package rxblk_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FRAME  = 2'd1,
    ST_PARITY = 2'd2,
    ST_BREAK  = 2'd3
  } rx_stat_e;

  function automatic rx_stat_e stat_encode(input logic brk, input logic perr, input logic ferr);
    if (brk)       return ST_BREAK;
    else if (perr) return ST_PARITY;
    else if (ferr) return ST_FRAME;
    else           return ST_CLEAN;
  endfunction
endpackage

// File: rtl/rxblk_store.sv
module rxblk_store #(
  parameter int W  = 10,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int N = 1 << AW;

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxblk_ctrl.sv
module rxblk_ctrl #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          cmd_release,
  input  logic          cmd_force,
  input  logic          cmd_reset,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] base_addr,
  output logic [CW-1:0] occupied,
  output logic          holding,
  output logic          ev_full,
  output logic          ev_term,
  output logic          ev_ovf,
  output logic [AW-1:0] blk_count
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [AW-1:0] wr_ptr, base;
  logic [CW-1:0] occ, blk_len;
  logic          hold_q;
  logic          room, accept, rel, dlv_full, dlv_force;

  always_comb begin
    room      = (occ != FULL_LVL);
    accept    = rx_valid && room && !cmd_reset && !rst;
    rel       = cmd_release && hold_q;
    dlv_full  = !hold_q && (occ == FULL_LVL);
    dlv_force = !hold_q && cmd_force && (occ != '0) && !dlv_full;
  end

  always_ff @(posedge clk) begin
    if (rst || cmd_reset) begin
      wr_ptr  <= '0;
      base    <= '0;
      occ     <= '0;
      blk_len <= '0;
      hold_q  <= 1'b0;
      ev_full <= 1'b0;
      ev_term <= 1'b0;
      ev_ovf  <= 1'b0;
    end else begin
      wr_ptr  <= wr_ptr + AW'(accept);
      occ     <= occ + CW'(accept) - (rel ? blk_len : '0);
      ev_full <= dlv_full;
      ev_term <= dlv_force;
      ev_ovf  <= rx_valid && !room;
      if (rel) begin
        base   <= base + blk_len[AW-1:0];
        hold_q <= 1'b0;
      end else if (dlv_full || dlv_force) begin
        hold_q  <= 1'b1;
        blk_len <= occ;
      end
    end
  end

  assign wr_en     = accept;
  assign wr_addr   = wr_ptr;
  assign base_addr = base;
  assign occupied  = occ;
  assign holding   = hold_q;
  assign blk_count = blk_len[AW-1:0];
endmodule

// File: rtl/rxblk_idle_timer.sv
module rxblk_idle_timer #(
  parameter int LIMIT = 32,
  parameter int TW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic armed,
  output logic ev_timeout
);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt;
  logic          fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      fired      <= 1'b0;
      ev_timeout <= 1'b0;
    end else begin
      ev_timeout <= 1'b0;
      if (clear) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (armed && !fired) begin
        if (cnt == LAST) begin
          ev_timeout <= 1'b1;
          fired      <= 1'b1;
          cnt        <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/rxblk_fifo.sv
module rxblk_fifo
  import rxblk_pkg::*;
#(
  parameter int DEPTH         = 32,
  parameter int DW            = 8,
  parameter int CHAR_CYCLES   = 8,
  parameter int TIMEOUT_CHARS = 4,
  parameter int AW            = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    rd_stat,
  input  logic          cmd_release,
  input  logic          cmd_force,
  input  logic          cmd_reset,
  output logic          ev_full,
  output logic          ev_term,
  output logic          ev_timeout,
  output logic          ev_ovf,
  output logic          ev_brk,
  output logic          blk_ready,
  output logic [AW-1:0] blk_count
);
  localparam int CW         = AW + 1;
  localparam int EW         = DW + 2;
  localparam int IDLE_LIMIT = CHAR_CYCLES * TIMEOUT_CHARS;

  logic          wr_en, holding;
  logic [AW-1:0] wr_addr, base_addr;
  logic [CW-1:0] occupied;
  logic [EW-1:0] wr_word, rd_word;
  rx_stat_e      in_stat;

  assign in_stat = stat_encode(rx_brk, rx_perr, rx_ferr);
  assign wr_word = {in_stat, rx_data};

  rxblk_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_ctrl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid),
    .cmd_release(cmd_release), .cmd_force(cmd_force), .cmd_reset(cmd_reset),
    .wr_en(wr_en), .wr_addr(wr_addr), .base_addr(base_addr),
    .occupied(occupied), .holding(holding),
    .ev_full(ev_full), .ev_term(ev_term), .ev_ovf(ev_ovf),
    .blk_count(blk_count)
  );

  rxblk_store #(.W(EW), .AW(AW)) i_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_word),
    .re(rd_en), .raddr(base_addr + rd_idx), .rdata(rd_word)
  );

  rxblk_idle_timer #(.LIMIT(IDLE_LIMIT)) i_timer (
    .clk(clk), .rst(rst),
    .clear(wr_en || cmd_reset),
    .armed(!holding && (occupied != '0)),
    .ev_timeout(ev_timeout)
  );

  always_ff @(posedge clk) begin
    if (rst) ev_brk <= 1'b0;
    else     ev_brk <= wr_en && rx_brk;
  end

  assign rd_data   = rd_word[DW-1:0];
  assign rd_stat   = rd_word[EW-1:DW];
  assign blk_ready = holding;
endmodule

// File: rtl/rxblk_fifo_chk.sv
module rxblk_fifo_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic          rx_brk,
  input logic          cmd_release,
  input logic          cmd_reset,
  input logic          ev_full,
  input logic          ev_term,
  input logic          ev_ovf,
  input logic          ev_brk,
  input logic          blk_ready,
  input logic [AW-1:0] blk_count
);
  assert_full_count_R2: assert property (@(posedge clk) disable iff (rst)
    ev_full |-> (blk_ready && blk_count == '0));

  assert_one_delivery_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_full, ev_term}));

  assert_term_holds_R3: assert property (@(posedge clk) disable iff (rst)
    ev_term |-> blk_ready);

  assert_hold_until_release_R5: assert property (@(posedge clk) disable iff (rst)
    (blk_ready && !cmd_release && !cmd_reset) |=> blk_ready);

  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (rst)
    ev_ovf |-> $past(rx_valid));

  assert_brk_cause_R8: assert property (@(posedge clk) disable iff (rst)
    ev_brk |-> $past(rx_valid && rx_brk));

  assert_reset_empties_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> (!blk_ready && !ev_full && !ev_term));
endmodule

bind rxblk_fifo rxblk_fifo_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_brk(rx_brk),
  .cmd_release(cmd_release), .cmd_reset(cmd_reset),
  .ev_full(ev_full), .ev_term(ev_term), .ev_ovf(ev_ovf), .ev_brk(ev_brk),
  .blk_ready(blk_ready), .blk_count(blk_count)
);

// File: tb/test_rxblk_fifo.sv
module test_rxblk_fifo;
  localparam int DEPTH = 32;
  localparam int DW    = 8;
  localparam int AW    = 5;
  localparam int CHARC = 8;
  localparam int TCH   = 4;
  localparam int LIM   = CHARC * TCH;

  localparam int K_FULL = 0, K_TERM = 1, K_TO = 2, K_OVF = 3, K_BRK = 4;

  logic clk = 0, rst = 1;
  logic rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic [DW-1:0] rx_data = '0;
  logic rd_en = 0;
  logic [AW-1:0] rd_idx = '0;
  logic [DW-1:0] rd_data;
  logic [1:0] rd_stat;
  logic cmd_release = 0, cmd_force = 0, cmd_reset = 0;
  logic ev_full, ev_term, ev_timeout, ev_ovf, ev_brk, blk_ready;
  logic [AW-1:0] blk_count;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { int kind; int cnt; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  rxblk_fifo #(.DEPTH(DEPTH), .DW(DW), .CHAR_CYCLES(CHARC), .TIMEOUT_CHARS(TCH)) i_rxblk_fifo (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_stat(rd_stat),
    .cmd_release(cmd_release), .cmd_force(cmd_force), .cmd_reset(cmd_reset),
    .ev_full(ev_full), .ev_term(ev_term), .ev_timeout(ev_timeout),
    .ev_ovf(ev_ovf), .ev_brk(ev_brk), .blk_ready(blk_ready), .blk_count(blk_count)
  );

  function automatic string kname(int k);
    case (k)
      K_FULL: return "R2 full";
      K_TERM: return "R3 term";
      K_TO:   return "R4 timeout";
      K_OVF:  return "R6 overflow";
      default: return "R8 break";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input int c);
    exp_t e;
    e.kind = k; e.cnt = c;
    q.push_back(e);
  endtask

  // monitor: pops expected events as they appear
  task automatic see(input int k, input int c);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL %s: unexpected event, actual kind %0d expected none", kname(k), k);
    end else begin
      e = q.pop_front();
      if (e.kind != k || (k <= K_TERM && e.cnt != c)) begin
        fails++;
        $display("FAIL %s: actual kind %0d count %0d expected kind %0d count %0d",
                 kname(e.kind), k, c, e.kind, e.cnt);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ev_full)    see(K_FULL, int'(blk_count));
      if (ev_term)    see(K_TERM, int'(blk_count));
      if (ev_timeout) see(K_TO, 0);
      if (ev_ovf)     see(K_OVF, 0);
      if (ev_brk)     see(K_BRK, 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic p, input logic f, input logic b);
    rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    @(posedge clk); @(negedge clk);
    rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  task automatic cmd(input int which);
    if (which == 0) cmd_release = 1;
    else if (which == 1) cmd_force = 1;
    else cmd_reset = 1;
    @(posedge clk); @(negedge clk);
    cmd_release = 0; cmd_force = 0; cmd_reset = 0;
  endtask

  task automatic rd(input int idx, input int exp_d, input int exp_s, input string req);
    rd_en = 1; rd_idx = AW'(idx);
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    check(req, int'(rd_data), exp_d);
    check(req, int'(rd_stat), exp_s);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R10 reset state
    check("R10 events", int'({ev_full, ev_term, ev_timeout, ev_ovf, ev_brk}), 0);
    check("R10 blk_ready", int'(blk_ready), 0);
    check("R10 blk_count", int'(blk_count), 0);

    // partial block with mixed status (R7, R8), timeout timing (R4)
    send(8'h11, 0, 0, 0);
    send(8'h22, 1, 0, 0);
    send(8'h33, 0, 1, 0);
    expect_ev(K_BRK, 0);
    send(8'h00, 1, 1, 1);
    expect_ev(K_TO, 0);
    send(8'h55, 1, 1, 0);
    repeat (LIM - 1) @(posedge clk);
    @(negedge clk);
    check("R4 not early", int'(ev_timeout), 0);
    @(posedge clk); @(negedge clk);
    check("R4 on time", int'(ev_timeout), 1);
    idle(2 * LIM);
    check("R4 no repeat queue", q.size(), 0);

    expect_ev(K_TERM, 5);
    cmd(1);
    check("R3 blk_count", int'(blk_count), 5);
    rd(0, 8'h11, 0, "R1/R7 idx0");
    rd(1, 8'h22, 2, "R7 parity");
    rd(2, 8'h33, 1, "R7 framing");
    rd(3, 8'h00, 3, "R7 break wins");
    rd(4, 8'h55, 2, "R7 parity over framing");
    cmd(1); idle(2);                       // R3 force ignored while outstanding
    check("R3 count kept", int'(blk_count), 5);
    send(8'h66, 0, 0, 0);
    send(8'h67, 0, 0, 0);
    rd(0, 8'h11, 0, "R1 held until release");
    cmd(0);
    check("R5 released", int'(blk_ready), 0);
    expect_ev(K_TERM, 2);
    cmd(1);
    rd(0, 8'h66, 0, "R5 next block idx0");
    rd(1, 8'h67, 0, "R5 next block idx1");
    cmd(0);

    // full pool (R2) and overflow (R6)
    expect_ev(K_FULL, 0);
    for (int i = 0; i < DEPTH; i++) send(8'(8'h40 + i), 0, 0, 0);
    idle(2);
    check("R2 blk_ready", int'(blk_ready), 1);
    check("R2 count mod 32", int'(blk_count), 0);
    rd(0, 8'h40, 0, "R2 idx0");
    rd(31, 8'h5F, 0, "R2 idx31");
    expect_ev(K_OVF, 0);
    send(8'hEE, 0, 0, 0);
    idle(1);
    rd(31, 8'h5F, 0, "R6 data kept idx31");
    rd(0, 8'h40, 0, "R6 data kept idx0");
    cmd(0); idle(1);
    check("R5 release after full", int'(blk_ready), 0);
    cmd(1); idle(2);                       // R3 ignored: pool empty, overflow byte dropped
    check("R6 dropped byte not stored", int'(blk_ready), 0);
    send(8'h77, 0, 0, 0);
    expect_ev(K_TERM, 1);
    cmd(1);
    rd(0, 8'h77, 0, "R5 idx0 after full");
    cmd(0);

    // reset command (R9)
    send(8'hA1, 0, 0, 0);
    send(8'hA2, 0, 0, 0);
    send(8'hA3, 0, 0, 0);
    cmd(2); idle(1);
    check("R9 blk_ready", int'(blk_ready), 0);
    cmd(1); idle(2);
    check("R9 force finds nothing", int'(blk_ready), 0);
    send(8'hB0, 0, 0, 0);
    expect_ev(K_TERM, 1);
    cmd(1);
    rd(0, 8'hB0, 0, "R9 idx0 after reset");
    cmd(0);
    idle(LIM + 8);
    check("all expected events seen", q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule